// File: doc/BRIEF.md
# Serial Flash Boot Loader (SPI Master)

This block runs straight out of reset and copies a boot kernel from an external serial memory into on-chip word memory. It acts as an SPI master in mode 0. It drives the serial clock, the data output and a single active-low device select, and it samples the data input. Every transfer begins with one 32-bit read command. The command holds an 8-bit opcode and a 24-bit source address. The 32 bits that arrive while the command goes out are dropped. After that, the block receives a fixed number of 32-bit words and writes each one through a plain memory write port.

All serial traffic is least-significant-bit first, in both directions. The serial clock is the core clock divided by a parameter, 400 by default, which gives 500 kHz from a 200 MHz core. Words are written to consecutive addresses from a fixed base. When the last word has been written, a one-cycle completion interrupt pulses. Leaving reset starts a load on its own. A `start` pulse starts a new load only while the block is idle.

Top module: `spi_boot_loader`

## Requirements
- R1: While reset is low, `spi_ss_n` is 1, `spi_sclk` is 0, `mem_we` is 0, `done_irq` is 0 and `busy` is 1. After reset is released, a load starts without any `start` pulse.
- R2: The command word is `{SRC_ADDR[23:0], OPCODE[7:0]}`. It goes out on `spi_mosi` bit 0 first, one bit per SCLK rising edge, across the first 32 rising edges.
- R3: The 32 bits received during the command are never written to memory. The first memory write carries bits 33 to 64 of the received stream.
- R4: Received data is assembled LSB-first. The first bit received for a word lands in bit 0, and the 32nd lands in bit 31.
- R5: SCLK idles low and has a period of `CLK_DIV` core cycles, high for `CLK_DIV/2` of them. `spi_mosi` changes only while SCLK is low (mode 0).
- R6: `spi_ss_n` falls at least `CLK_DIV/2` core cycles before the first SCLK rising edge. It stays low for all 32×(`WORD_COUNT`+1) bits and rises only with SCLK low, after the last bit.
- R7: Exactly `WORD_COUNT` writes are made. Word i goes to `MEM_BASE + i`, and each write strobe lasts one core cycle.
- R8: `done_irq` is a single-cycle pulse after the last write. `busy` drops on the cycle after that pulse.
- R9: A `start` pulse while `busy` is high is ignored. A `start` pulse while idle runs a complete new load.
- R10: Whenever `busy` is low, `spi_sclk` is 0 and `spi_ss_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset; release launches a load |
| start | input | 1 | Pulse that starts a load while idle |
| spi_miso | input | 1 | Serial data from the memory |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the memory |
| spi_ss_n | output | 1 | Active-low device select |
| mem_addr | output | ADDR_W | Word write address |
| mem_wdata | output | WORD_W | Word write data |
| mem_we | output | 1 | One-cycle write strobe |
| busy | output | 1 | High while a load is in progress |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
Faults in the bit or word counters show up at the ports. An off-by-one in the bit counter changes the number of SCLK rising edges seen before select rises, and it also skews every written word by one bit position, so the first write already carries the wrong data. A word counter that fails to skip the command slot makes an extra write to `MEM_BASE` within about 64 serial clocks. A wrong finish count moves the done pulse and the write total. A fault in the divider or the clock phase makes MOSI change while SCLK is high, or gives a wrong period on the first bit.

// File: rtl/spi_boot_pkg.sv
// Package: shared state type and command-word builder for the boot loader.
// Assumes the command is always 32 bits: opcode in the low byte, so it is
// the first byte shifted out in LSB-first order.
package spi_boot_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_SETUP,
        ST_XFER,
        ST_FINISH
    } boot_state_e;

    // Builds the read command word from opcode and 24-bit source address.
    function automatic logic [31:0] make_read_cmd(input logic [7:0] op,
                                                  input logic [23:0] src);
        return {src, op};
    endfunction
endpackage

// File: rtl/spi_half_tick.sv
// Module: spi_half_tick
// Emits a one-cycle tick every HALF core cycles while enabled. The count
// clears whenever the enable is low, so the first tick comes exactly HALF
// cycles after the enable rises. Assumes HALF >= 1.
module spi_half_tick #(
    parameter int HALF = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == CW'(HALF - 1));

    // Counts core cycles within one SCLK half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) cnt_q <= '0;
        else                       cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/spi_lsb_shifter.sv
// Module: spi_lsb_shifter
// Transmit and receive shift registers for LSB-first serial data. The
// transmit side loads the command and shifts right on each falling SCLK
// edge, filling with zeros. The receive side shifts MISO in at the top on
// each rising edge, so the first bit of a word ends up in bit 0.
module spi_lsb_shifter #(
    parameter int          WORD_W = 32,
    parameter logic [31:0] CMD    = 32'h0000_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cmd,
    input  logic              shift_tx,
    input  logic              sample_rx,
    input  logic              miso,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_next
);
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;

    assign mosi    = tx_q[0];
    assign rx_next = {miso, rx_q[WORD_W-1:1]};

    // Loads the command and shifts it out one bit per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_q <= '0;
        else if (load_cmd) tx_q <= WORD_W'(CMD);
        else if (shift_tx) tx_q <= tx_q >> 1;
    end

    // Captures MISO on each rising edge into the word being assembled.
    always_ff @(posedge clk) begin
        if (!rst_n)         rx_q <= '0;
        else if (sample_rx) rx_q <= rx_next;
    end
endmodule

// File: rtl/spi_boot_seq.sv
// Module: spi_boot_seq
// Control for the boot transfer: state machine, SCLK phase, bit and word
// counters, and the registered memory write port. Word slot 0 is the
// command; the data received in that slot is never written. Assumes WORD_W
// is a power of two, so the bit counter wraps naturally.
module spi_boot_seq
    import spi_boot_pkg::*;
#(
    parameter int                WORD_W     = 32,
    parameter int                ADDR_W     = 32,
    parameter int                WORD_COUNT = 384,
    parameter logic [ADDR_W-1:0] MEM_BASE   = 'h0008_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    input  logic [WORD_W-1:0] rx_next,
    output logic              tick_en,
    output logic              load_cmd,
    output logic              shift_tx,
    output logic              sample_rx,
    output logic              sclk,
    output logic              ss_n,
    output logic              busy,
    output logic              done_irq,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we
);
    localparam int BW  = $clog2(WORD_W);
    localparam int WCW = $clog2(WORD_COUNT + 2);

    boot_state_e        state_q;
    logic               sclk_q;
    logic [BW-1:0]      bit_q;
    logic [WCW-1:0]     word_q;
    logic               rise, fall, word_end, last_fall, active;
    logic [ADDR_W-1:0]  addr_q;
    logic [WORD_W-1:0]  wdata_q;
    logic               we_q;

    assign active    = (state_q == ST_SETUP) || (state_q == ST_XFER);
    assign rise      = tick && ((state_q == ST_SETUP) || ((state_q == ST_XFER) && !sclk_q));
    assign fall      = tick && (state_q == ST_XFER) && sclk_q;
    assign word_end  = rise && (bit_q == BW'(WORD_W - 1));
    assign last_fall = fall && (word_q == WCW'(WORD_COUNT + 1));

    assign tick_en   = active;
    assign load_cmd  = (state_q == ST_LAUNCH);
    assign shift_tx  = fall;
    assign sample_rx = rise;
    assign sclk      = sclk_q;
    assign ss_n      = !active;
    assign busy      = (state_q != ST_IDLE);
    assign done_irq  = (state_q == ST_FINISH);
    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign mem_we    = we_q;

    // Sequences launch, select setup, bit transfer and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LAUNCH;
        else begin
            unique case (state_q)
                ST_IDLE:   if (start) state_q <= ST_LAUNCH;
                ST_LAUNCH: state_q <= ST_SETUP;
                ST_SETUP:  if (tick) state_q <= ST_XFER;
                ST_XFER:   if (last_fall) state_q <= ST_FINISH;
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Tracks the serial clock level: high on a rise tick, low on a fall tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    sclk_q <= 1'b0;
        else if (rise) sclk_q <= 1'b1;
        else if (fall) sclk_q <= 1'b0;
    end

    // Counts bits within a word and whole words, the command included.
    always_ff @(posedge clk) begin
        if (!rst_n || load_cmd) begin
            bit_q  <= '0;
            word_q <= '0;
        end else if (rise) begin
            bit_q <= bit_q + BW'(1);
            if (word_end) word_q <= word_q + WCW'(1);
        end
    end

    // Writes each completed data word and skips the command slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            we_q <= word_end && (word_q != '0);
            if (word_end && (word_q != '0)) begin
                wdata_q <= rx_next;
                addr_q  <= MEM_BASE + ADDR_W'(word_q) - ADDR_W'(1);
            end
        end
    end
endmodule

// File: rtl/spi_boot_loader.sv
// Module: spi_boot_loader (top)
// SPI master boot loader in mode 0. Sends a 32-bit LSB-first read command,
// drops the bits received with it, then streams WORD_COUNT words into
// memory from MEM_BASE and pulses done_irq. Assumes CLK_DIV is even and at
// least 2, and WORD_W is 32.
module spi_boot_loader
    import spi_boot_pkg::*;
#(
    parameter int                CLK_DIV    = 400,
    parameter int                WORD_COUNT = 384,
    parameter int                ADDR_W     = 32,
    parameter int                WORD_W     = 32,
    parameter logic [7:0]        OPCODE     = 8'h03,
    parameter logic [23:0]       SRC_ADDR   = 24'h00_0000,
    parameter logic [ADDR_W-1:0] MEM_BASE   = 'h0008_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              spi_miso,
    output logic              spi_sclk,
    output logic              spi_mosi,
    output logic              spi_ss_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              busy,
    output logic              done_irq
);
    localparam int          HALF = CLK_DIV / 2;
    localparam logic [31:0] CMD  = make_read_cmd(OPCODE, SRC_ADDR);

    logic              tick, tick_en, load_cmd, shift_tx, sample_rx;
    logic [WORD_W-1:0] rx_next;

    spi_half_tick #(.HALF(HALF)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(tick_en), .tick(tick)
    );

    spi_lsb_shifter #(.WORD_W(WORD_W), .CMD(CMD)) u_shift (
        .clk(clk), .rst_n(rst_n), .load_cmd(load_cmd), .shift_tx(shift_tx),
        .sample_rx(sample_rx), .miso(spi_miso), .mosi(spi_mosi), .rx_next(rx_next)
    );

    spi_boot_seq #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .WORD_COUNT(WORD_COUNT), .MEM_BASE(MEM_BASE)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .rx_next(rx_next),
        .tick_en(tick_en), .load_cmd(load_cmd), .shift_tx(shift_tx),
        .sample_rx(sample_rx), .sclk(spi_sclk), .ss_n(spi_ss_n), .busy(busy),
        .done_irq(done_irq), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
    );
endmodule

// File: rtl/spi_boot_loader_chk.sv
// Module: spi_boot_loader_chk
// Port-level checker bound to spi_boot_loader. It keeps its own count of
// writes per load and checks addressing and completion against it.
module spi_boot_loader_chk #(
    parameter int                WORD_COUNT = 384,
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] MEM_BASE   = 'h0008_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_sclk,
    input logic              spi_mosi,
    input logic              spi_ss_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              busy,
    input logic              done_irq
);
    logic [31:0] wr_seen_q;

    // Counts the writes made in the current load.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) wr_seen_q <= '0;
        else if (mem_we)     wr_seen_q <= wr_seen_q + 32'd1;
    end

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!spi_sclk && spi_ss_n));
    p_sclk_in_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_ss_n);
    p_mosi_held_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sclk) |-> $stable(spi_mosi));
    p_write_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == MEM_BASE + ADDR_W'(wr_seen_q)));
    p_write_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wr_seen_q < 32'(WORD_COUNT)));
    p_write_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
    p_done_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (wr_seen_q == 32'(WORD_COUNT)));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> (!done_irq && !busy));
    p_busy_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done_irq) |=> busy);
endmodule

bind spi_boot_loader spi_boot_loader_chk #(
    .WORD_COUNT(WORD_COUNT), .ADDR_W(ADDR_W), .MEM_BASE(MEM_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_ss_n(spi_ss_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .busy(busy), .done_irq(done_irq)
);

// File: tb/tb_spi_boot_loader.sv
// Bench for spi_boot_loader: a serial memory model feeds a seeded random or
// directed stream; monitors on the falling core clock edge check framing,
// timing and written words against values computed from the requirements.
module tb_spi_boot_loader;
    localparam int          CLK_PERIOD = 10;
    localparam int          CLK_DIV    = 4;
    localparam int          HALF       = CLK_DIV / 2;
    localparam int          WC         = 8;
    localparam int          NBITS      = 32 * (WC + 1);
    localparam logic [7:0]  OPC        = 8'hA5;
    localparam logic [23:0] SRC        = 24'h12_3456;
    localparam logic [31:0] BASE       = 32'h0008_0000;

    logic clk = 0, rst_n = 0, start = 0, miso = 0;
    logic sclk, mosi, ss_n, mem_we, busy, done_irq;
    logic [31:0] mem_addr, mem_wdata;

    int tests = 0, fails = 0;

    spi_boot_loader #(.CLK_DIV(CLK_DIV), .WORD_COUNT(WC), .OPCODE(OPC),
                      .SRC_ADDR(SRC), .MEM_BASE(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .spi_miso(miso),
        .spi_sclk(sclk), .spi_mosi(mosi), .spi_ss_n(ss_n), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy), .done_irq(done_irq));

    always #(CLK_PERIOD/2) clk = ~clk;

    // Serial memory model: stream[0] is junk sent during the command.
    logic [31:0] stream [WC+1];
    int sbit = 0;
    always @(negedge ss_n) begin sbit = 0; miso = stream[0][0]; end
    always @(negedge sclk) if (!ss_n) begin
        sbit++;
        if (sbit < NBITS) miso = stream[sbit/32][sbit%32];
    end

    // Monitor state
    logic [31:0] cap_cmd, wr_addr [WC+4], wr_data [WC+4];
    int rise_cnt, wr_cnt, done_cnt, since_rise, since_ss, high_len;
    int err_clk, err_mode, err_ss, err_idle, err_busy;
    logic p_sclk = 0, p_mosi = 0, p_ss = 1, p_done = 0;

    task automatic clear_mon();
        cap_cmd = 0; rise_cnt = 0; wr_cnt = 0; done_cnt = 0; since_rise = 0;
        since_ss = 0; high_len = 0; err_clk = 0; err_mode = 0; err_ss = 0;
        err_idle = 0; err_busy = 0;
    endtask

    always @(negedge clk) if (rst_n) begin
        since_rise++; since_ss++;
        if (sclk) high_len++;
        if (sclk && !p_sclk) begin
            if (rise_cnt < 32) cap_cmd[rise_cnt] = mosi;
            if (rise_cnt == 0 && since_ss < HALF) err_ss++;
            if (rise_cnt > 0 && since_rise != CLK_DIV) err_clk++;
            if (ss_n) err_ss++;
            rise_cnt++; since_rise = 0;
        end
        if (!sclk && p_sclk) begin
            if (high_len != HALF) err_clk++;
            high_len = 0;
        end
        if (mosi != p_mosi && sclk) err_mode++;
        if (!ss_n && p_ss) since_ss = 0;
        if (ss_n && !p_ss && (rise_cnt != NBITS || sclk)) err_ss++;
        if (!busy && (sclk || !ss_n)) err_idle++;
        if (p_done && busy) err_busy++;
        if (mem_we) begin
            if (wr_cnt < WC + 4) begin wr_addr[wr_cnt] = mem_addr; wr_data[wr_cnt] = mem_wdata; end
            wr_cnt++;
        end
        if (done_irq) begin done_cnt++; if (p_done) err_busy++; end
        p_sclk = sclk; p_mosi = mosi; p_ss = ss_n; p_done = done_irq;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_cmd();
        return {SRC, OPC};
    endfunction

    function automatic logic [31:0] exp_addr(input int i);
        return BASE + 32'(i);
    endfunction

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            @(negedge clk);
            if (done_irq) seen = 1;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_load(input string tag);
        bit data_ok = 1;
        for (int i = 0; i < WC; i++)
            if (wr_data[i] !== stream[i+1] || wr_addr[i] !== exp_addr(i)) data_ok = 0;
        chk(cap_cmd == exp_cmd(), {"R2 command ", tag}, cap_cmd, exp_cmd());
        chk(wr_cnt == WC, {"R7 write count ", tag}, 32'(wr_cnt), 32'(WC));
        chk(data_ok, {"R4 R7 words/addresses ", tag}, wr_data[0], stream[1]);
        chk(wr_data[0] !== stream[0] || stream[0] == stream[1], {"R3 command slot dropped ", tag},
            wr_data[0], stream[1]);
        chk(err_clk == 0 && err_mode == 0, {"R5 sclk timing/mode ", tag},
            32'(err_clk), 32'(err_mode));
        chk(err_ss == 0 && rise_cnt == NBITS, {"R6 select framing ", tag},
            32'(rise_cnt), 32'(NBITS));
        chk(done_cnt == 1 && err_busy == 0, {"R8 done pulse ", tag},
            32'(done_cnt), 32'd1);
        chk(err_idle == 0 && !busy, {"R10 idle lines ", tag}, 32'(err_idle), 32'd0);
    endtask

    bit wd_hit = 0;
    initial begin
        #(CLK_PERIOD * 200000);
        wd_hit = 1;
        fails++; tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit seen;
        void'($urandom(32'd20240611));
        for (int i = 0; i <= WC; i++) stream[i] = $urandom();
        clear_mon();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ss_n && !sclk && !mem_we && !done_irq && busy, "R1 reset state",
            {28'd0, ss_n, sclk, mem_we, done_irq}, 32'h8);
        @(negedge clk); rst_n = 1;
        // Boot 1: launched by reset release, random data
        wait_done(seen);
        chk(seen, "R1 auto launch after reset", 32'(seen), 32'd1);
        check_load("boot1");

        // Boot 2: start pulse from idle, with a start pulse while busy (R9)
        for (int i = 0; i <= WC; i++) stream[i] = $urandom();
        clear_mon();
        repeat (5) @(negedge clk);
        chk(!busy && ss_n, "R9 stays idle without start", 32'(busy), 32'd0);
        start = 1; @(negedge clk); start = 0;
        repeat (300) @(negedge clk);
        start = 1; @(negedge clk); start = 0;
        wait_done(seen);
        chk(seen, "R9 start from idle runs a load", 32'(seen), 32'd1);
        check_load("boot2");
        repeat (400) @(negedge clk);
        chk(!busy && wr_cnt == WC && done_cnt == 1, "R9 start while busy ignored",
            32'(wr_cnt), 32'(WC));

        // Boot 3: directed corner patterns, junk of all ones
        stream[0] = 32'hFFFF_FFFF;
        for (int i = 1; i <= WC; i++)
            case (i % 4)
                0: stream[i] = 32'h8000_0001;
                1: stream[i] = 32'h0000_0000;
                2: stream[i] = 32'hAAAA_5555;
                default: stream[i] = 32'h0000_0001 << i;
            endcase
        clear_mon();
        start = 1; @(negedge clk); start = 0;
        wait_done(seen);
        chk(seen, "R8 directed load completes", 32'(seen), 32'd1);
        check_load("boot3");
        chk(wr_data[0] == 32'h0, "R3 junk ones not in first word", wr_data[0], 32'h0);

        if (!wd_hit) begin
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule